// File: doc/BRIEF.md
# Micro Translation Buffer with Two-Level Pseudo-LRU Refill

This block is a small, fully associative page translation cache placed in front of a larger joint translation table. Each cycle it takes a virtual page number and an address-space identifier (ASID). It answers in the same cycle with a hit flag, a 24-bit physical frame number and cache-attribute bits. Each entry covers one 4KB page. An entry matches when its page number is equal to the request and either its ASID is equal or its global flag is set.

On a miss the block raises a stall and captures the request. From the next cycle it holds a lookup request towards the joint table until an answer returns. A successful answer is written into a victim entry chosen by pseudo-LRU, and the requester's retried lookup then hits. An answer flagged as a miss writes nothing and is passed back as a translation fault.

The entry count is a parameter, 2 or 4. With 4 entries, one bit names the least recently used pair and one bit per pair names the older entry inside that pair. With 2 entries a single bit names the older entry. A flush input invalidates every entry at once and is used whenever the joint table is rewritten.

Top module: `micro_tlb`

## Requirements
- R1: After a synchronous active-low reset, all entries are invalid. `jt_req`, `lk_hit`, `lk_stall` and `lk_fault` are low, and the first lookup misses.
- R2: When idle, a lookup with `lk_valid` high that matches a valid entry drives `lk_hit` high in the same cycle, with that entry's `lk_pfn` and `lk_attr`, and `lk_stall` low.
- R3: An entry with its global flag clear matches only when its ASID is equal to `lk_asid`. An entry with its global flag set matches under any ASID.
- R4: When idle, a lookup that misses raises `lk_stall` in the same cycle. From the next cycle `jt_req` is high and `jt_vpn`/`jt_asid` carry the missed request. Both stay unchanged until a response or a flush arrives.
- R5: While `jt_req` is high, `lk_hit` is low and `lk_stall` is high, whatever is on the lookup inputs.
- R6: A response with `jt_rsp_valid` high and `jt_rsp_miss` low, taken while `jt_req` is high, writes the returned mapping. `jt_req` is low in the next cycle, and the retried lookup hits with the returned frame and attributes.
- R7: Every hit and every refill marks the used entry as most recent. Entry index bit 1 selects the pair and bit 0 selects the entry within the pair. A refill overwrites the least recently used entry of the least recently used pair. From reset, refills therefore fill entries 0, 2, 1 and 3 in that order, and all four mappings stay resident.
- R8: A response with `jt_rsp_miss` high, taken while `jt_req` is high, raises `lk_fault` in that same cycle. It changes no entry and returns the block to idle.
- R9: One cycle of `flush` invalidates every entry and cancels any outstanding request, so `jt_req` is low in the next cycle.
- R10: A response that arrives while `jt_req` is low has no effect on the contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W (20) | Virtual page number to translate |
| lk_asid | input | ASID_W (8) | Address-space identifier of the lookup |
| lk_hit | output | 1 | Translation found this cycle |
| lk_pfn | output | PFN_W (24) | Physical frame number of the hit |
| lk_attr | output | ATTR_W (3) | Cache-attribute bits of the hit |
| lk_stall | output | 1 | Lookup missed or refill outstanding |
| lk_fault | output | 1 | Joint table reported no mapping |
| flush | input | 1 | Invalidate all entries, cancel refill |
| jt_req | output | 1 | Lookup request to the joint table, held until answered |
| jt_vpn | output | VPN_W (20) | Page number being refilled |
| jt_asid | output | ASID_W (8) | ASID being refilled |
| jt_rsp_valid | input | 1 | Joint table answer present |
| jt_rsp_miss | input | 1 | Answer carries no mapping |
| jt_rsp_global | input | 1 | Returned mapping ignores ASID |
| jt_rsp_pfn | input | PFN_W (24) | Returned frame number |
| jt_rsp_attr | input | ATTR_W (3) | Returned cache attributes |

## Verification
A corrupted recency bit does not show at once. It shows only at the next refill, when a mapping that was just used disappears, and that is seen when a later lookup of it misses and stalls. The bench therefore touches entries in a chosen order before a refill and then probes every page. A stuck valid bit or a lost capture of the missed page shows within a cycle or two, as a wrong hit or a wrong `jt_vpn`. A controller left waiting shows as `lk_stall` staying high and `lk_hit` staying low after a response or a flush.

// File: rtl/mtlb_pkg.sv
// Package: shared types and default widths for the micro translation buffer.
// Assumes 4KB pages and a 36-bit physical space (24-bit frame number).
package mtlb_pkg;
    localparam int MT_ENTRIES_DEF = 4;
    localparam int MT_VPN_W_DEF   = 20;
    localparam int MT_ASID_W_DEF  = 8;
    localparam int MT_PFN_W_DEF   = 24;
    localparam int MT_ATTR_W_DEF  = 3;

    typedef enum logic {
        MT_IDLE = 1'b0,
        MT_WAIT = 1'b1
    } mt_state_e;
endpackage

// File: rtl/mtlb_entry_array.sv
// Module: entry storage and associative match.
// Holds N entries (valid, page, ASID, global, frame, attributes).
// Flush has priority over a write in the same cycle.
// Assumes at most one entry matches; if more do, the lowest index wins.
module mtlb_entry_array #(
    parameter int N      = 4,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 24,
    parameter int ATTR_W = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              match,
    output logic [IDX_W-1:0]  match_idx,
    output logic [PFN_W-1:0]  match_pfn,
    output logic [ATTR_W-1:0] match_attr
);
    logic [N-1:0]      valid_q;
    logic [N-1:0]      glob_q;
    logic [VPN_W-1:0]  vpn_q  [N];
    logic [ASID_W-1:0] asid_q [N];
    logic [PFN_W-1:0]  pfn_q  [N];
    logic [ATTR_W-1:0] attr_q [N];
    logic [N-1:0]      hit_vec;

    // Valid bits: cleared by reset or flush, set by a refill write.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (flush) valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Payload fields: loaded on refill, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            vpn_q[wr_idx]  <= wr_vpn;
            asid_q[wr_idx] <= wr_asid;
            glob_q[wr_idx] <= wr_glob;
            pfn_q[wr_idx]  <= wr_pfn;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    // Per-entry comparators.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) &&
                            (glob_q[g] || (asid_q[g] == lk_asid));
    end

    // Select the matching entry, lowest index last so it wins.
    always_comb begin
        match      = 1'b0;
        match_idx  = '0;
        match_pfn  = '0;
        match_attr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                match      = 1'b1;
                match_idx  = IDX_W'(i);
                match_pfn  = pfn_q[i];
                match_attr = attr_q[i];
            end
        end
    end
endmodule

// File: rtl/mtlb_plru.sv
// Module: pseudo-LRU replacement state.
// N=4: one bit points to the older pair, one bit per pair to the older entry.
// N=2: one bit points to the older entry. Only N of 2 or 4 is supported.
module mtlb_plru #(
    parameter int N      = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    if (N == 4) begin : g_tree
        logic       pair_lru_q;
        logic [1:0] ent_lru_q;

        // Mark the touched entry and its pair as most recent.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pair_lru_q <= 1'b0;
                ent_lru_q  <= 2'b00;
            end else if (touch_en) begin
                pair_lru_q             <= ~touch_idx[1];
                ent_lru_q[touch_idx[1]] <= ~touch_idx[0];
            end
        end

        assign victim_idx = {pair_lru_q, ent_lru_q[pair_lru_q]};
    end else begin : g_pair
        logic lru_q;

        // Point at the entry that was not touched.
        always_ff @(posedge clk) begin
            if (!rst_n)        lru_q <= 1'b0;
            else if (touch_en) lru_q <= ~touch_idx[0];
        end

        assign victim_idx = lru_q;
    end
endmodule

// File: rtl/mtlb_refill_ctrl.sv
// Module: miss handling sequencer.
// Captures a missed request, holds it towards the joint table until answered,
// and raises fill or fault on the answer. Flush cancels the wait.
module mtlb_refill_ctrl #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_match,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              flush,
    input  logic              rsp_valid,
    input  logic              rsp_miss,
    output logic              busy,
    output logic [VPN_W-1:0]  req_vpn,
    output logic [ASID_W-1:0] req_asid,
    output logic              fill_en,
    output logic              fault
);
    import mtlb_pkg::*;

    mt_state_e state_q;
    logic      start;

    assign busy    = (state_q == MT_WAIT);
    assign start   = !busy && lk_valid && !lk_match && !flush;
    assign fill_en = busy && rsp_valid && !rsp_miss && !flush;
    assign fault   = busy && rsp_valid && rsp_miss && !flush;

    // State: enter wait on a miss, leave on an answer or a flush.
    always_ff @(posedge clk) begin
        if (!rst_n)                          state_q <= MT_IDLE;
        else if (start)                      state_q <= MT_WAIT;
        else if (busy && (flush || rsp_valid)) state_q <= MT_IDLE;
    end

    // Capture the missed page and ASID when the wait begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vpn  <= '0;
            req_asid <= '0;
        end else if (start) begin
            req_vpn  <= lk_vpn;
            req_asid <= lk_asid;
        end
    end
endmodule

// File: rtl/micro_tlb.sv
// Module: top of the micro translation buffer.
// Same-cycle lookup; on a miss it stalls, refills from the joint table into a
// pseudo-LRU victim, and reports a fault if the joint table has no mapping.
// Assumes the requester holds its lookup while lk_stall is high.
module micro_tlb #(
    parameter int NUM_ENTRIES = mtlb_pkg::MT_ENTRIES_DEF,
    parameter int VPN_W       = mtlb_pkg::MT_VPN_W_DEF,
    parameter int ASID_W      = mtlb_pkg::MT_ASID_W_DEF,
    parameter int PFN_W       = mtlb_pkg::MT_PFN_W_DEF,
    parameter int ATTR_W      = mtlb_pkg::MT_ATTR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              lk_stall,
    output logic              lk_fault,
    input  logic              flush,
    output logic              jt_req,
    output logic [VPN_W-1:0]  jt_vpn,
    output logic [ASID_W-1:0] jt_asid,
    input  logic              jt_rsp_valid,
    input  logic              jt_rsp_miss,
    input  logic              jt_rsp_global,
    input  logic [PFN_W-1:0]  jt_rsp_pfn,
    input  logic [ATTR_W-1:0] jt_rsp_attr
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic             match;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] touch_idx;
    logic             touch_en;
    logic             busy;
    logic             fill_en;

    mtlb_entry_array #(
        .N(NUM_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PFN_W(PFN_W), .ATTR_W(ATTR_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fill_en), .wr_idx(victim_idx),
        .wr_vpn(jt_vpn), .wr_asid(jt_asid), .wr_glob(jt_rsp_global),
        .wr_pfn(jt_rsp_pfn), .wr_attr(jt_rsp_attr),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .match(match), .match_idx(match_idx),
        .match_pfn(lk_pfn), .match_attr(lk_attr)
    );

    mtlb_refill_ctrl #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_match(match),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .flush(flush), .rsp_valid(jt_rsp_valid), .rsp_miss(jt_rsp_miss),
        .busy(busy), .req_vpn(jt_vpn), .req_asid(jt_asid),
        .fill_en(fill_en), .fault(lk_fault)
    );

    mtlb_plru #(.N(NUM_ENTRIES)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .victim_idx(victim_idx)
    );

    // Lookup outputs: hits only while idle; stall on a miss or a pending refill.
    assign lk_hit   = lk_valid && !busy && match;
    assign lk_stall = busy || (lk_valid && !match);
    assign jt_req   = busy;

    // Recency update: a refill marks its victim, a hit marks the matched entry.
    assign touch_en  = fill_en || (lk_hit && !flush);
    assign touch_idx = fill_en ? victim_idx : match_idx;
endmodule

// File: rtl/micro_tlb_checker.sv
// Module: protocol checks on the micro translation buffer ports.
// Attached to every micro_tlb instance by the bind below.
module micro_tlb_checker #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic              lk_stall,
    input logic              lk_fault,
    input logic              flush,
    input logic              jt_req,
    input logic [VPN_W-1:0]  jt_vpn,
    input logic [ASID_W-1:0] jt_asid,
    input logic              jt_rsp_valid,
    input logic              jt_rsp_miss
);
    // A hit needs a lookup.
    assert_hit_needs_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid && !lk_stall);

    // A miss while idle starts a request in the next cycle.
    assert_miss_starts_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!jt_req && lk_valid && !lk_hit && !flush) |=> jt_req);

    // The request and its page/ASID hold until answered or flushed.
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (jt_req && !jt_rsp_valid && !flush) |=> jt_req && $stable(jt_vpn) && $stable(jt_asid));

    // No hit while a refill is outstanding.
    assert_wait_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        jt_req |-> !lk_hit && lk_stall);

    // Any answer ends the wait.
    assert_answer_ends_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (jt_req && jt_rsp_valid) |=> !jt_req);

    // A fault only accompanies a miss answer to an outstanding request.
    assert_fault_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> jt_req && jt_rsp_valid && jt_rsp_miss);

    // After a flush nothing is pending and nothing hits.
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !jt_req && !lk_hit);
endmodule

bind micro_tlb micro_tlb_checker #(.VPN_W(VPN_W), .ASID_W(ASID_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_stall(lk_stall), .lk_fault(lk_fault), .flush(flush),
    .jt_req(jt_req), .jt_vpn(jt_vpn), .jt_asid(jt_asid),
    .jt_rsp_valid(jt_rsp_valid), .jt_rsp_miss(jt_rsp_miss)
);

// File: tb/test_micro_tlb.sv
// Bench: directed scenarios for micro_tlb, one task per scenario.
module test_micro_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W = 20, ASID_W = 8, PFN_W = 24, ATTR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic [ATTR_W-1:0] lk_attr;
    logic              lk_stall;
    logic              lk_fault;
    logic              flush = 1'b0;
    logic              jt_req;
    logic [VPN_W-1:0]  jt_vpn;
    logic [ASID_W-1:0] jt_asid;
    logic              jt_rsp_valid = 1'b0;
    logic              jt_rsp_miss = 1'b0;
    logic              jt_rsp_global = 1'b0;
    logic [PFN_W-1:0]  jt_rsp_pfn = '0;
    logic [ATTR_W-1:0] jt_rsp_attr = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    micro_tlb i_micro_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_attr(lk_attr),
        .lk_stall(lk_stall), .lk_fault(lk_fault), .flush(flush),
        .jt_req(jt_req), .jt_vpn(jt_vpn), .jt_asid(jt_asid),
        .jt_rsp_valid(jt_rsp_valid), .jt_rsp_miss(jt_rsp_miss),
        .jt_rsp_global(jt_rsp_global), .jt_rsp_pfn(jt_rsp_pfn),
        .jt_rsp_attr(jt_rsp_attr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Probe or use a lookup; a miss probe is withdrawn before the next edge.
    task automatic lookup(input string tag, input logic [VPN_W-1:0] vpn,
                          input logic [ASID_W-1:0] asid, input bit exp_hit,
                          input logic [PFN_W-1:0] exp_pfn);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
        #1;
        check({tag, " hit"}, lk_hit, exp_hit);
        if (exp_hit) check({tag, " pfn"}, lk_pfn, exp_pfn);
        else begin
            check({tag, " stall"}, lk_stall, 1'b1);
            lk_valid = 1'b0;
        end
    endtask

    // Miss, request, successful answer, then a hit on the retried lookup.
    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                          input logic [PFN_W-1:0] pfn, input logic [ATTR_W-1:0] attr,
                          input bit glob);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
        #1;
        check("R4 miss stalls", lk_stall, 1'b1);
        check("R4 miss no hit", lk_hit, 1'b0);
        @(negedge clk); #1;
        check("R4 request raised", jt_req, 1'b1);
        check("R4 request page", jt_vpn, vpn);
        check("R4 request asid", jt_asid, asid);
        check("R5 no hit while waiting", lk_hit, 1'b0);
        jt_rsp_valid = 1'b1; jt_rsp_miss = 1'b0; jt_rsp_global = glob;
        jt_rsp_pfn = pfn; jt_rsp_attr = attr;
        @(negedge clk);
        jt_rsp_valid = 1'b0;
        #1;
        check("R6 request dropped", jt_req, 1'b0);
        check("R6 retry hits", lk_hit, 1'b1);
        check("R6 retry pfn", lk_pfn, pfn);
        check("R6 retry attr", lk_attr, attr);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset req", jt_req, 1'b0);
        check("R1 reset stall", lk_stall, 1'b0);
        check("R1 reset hit", lk_hit, 1'b0);
        check("R1 reset fault", lk_fault, 1'b0);
        lookup("R1 empty lookup", 20'h00100, 8'd1, 1'b0, '0);
    endtask

    // Fills four pages; from reset they go to entries 0,2,1,3.
    task automatic t_fill();
        refill(20'h00100, 8'd1, 24'hA00001, 3'd1, 1'b0);
        refill(20'h00200, 8'd1, 24'hB00002, 3'd2, 1'b0);
        refill(20'h00300, 8'd2, 24'hC00003, 3'd3, 1'b1);
        refill(20'h00400, 8'd1, 24'hD00004, 3'd4, 1'b0);
        lookup("R7 all four resident A", 20'h00100, 8'd1, 1'b1, 24'hA00001);
        lookup("R7 all four resident B", 20'h00200, 8'd1, 1'b1, 24'hB00002);
        lookup("R7 all four resident C", 20'h00300, 8'd2, 1'b1, 24'hC00003);
        lookup("R2 D hit", 20'h00400, 8'd1, 1'b1, 24'hD00004);
    endtask

    task automatic t_asid();
        lookup("R3 nonglobal other asid", 20'h00100, 8'd7, 1'b0, '0);
        lookup("R3 global other asid", 20'h00300, 8'd7, 1'b1, 24'hC00003);
    endtask

    // Recency after A,B,C,D checks then C,A,D: older pair 0, older entry in it = C.
    task automatic t_victim();
        lookup("R7 touch A", 20'h00100, 8'd1, 1'b1, 24'hA00001);
        lookup("R7 touch D", 20'h00400, 8'd1, 1'b1, 24'hD00004);
        refill(20'h00500, 8'd1, 24'hE00005, 3'd5, 1'b0);
        lookup("R7 C evicted", 20'h00300, 8'd2, 1'b0, '0);
        lookup("R7 A kept", 20'h00100, 8'd1, 1'b1, 24'hA00001);
        lookup("R7 B kept", 20'h00200, 8'd1, 1'b1, 24'hB00002);
        lookup("R7 D kept", 20'h00400, 8'd1, 1'b1, 24'hD00004);
    endtask

    task automatic t_fault();
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h00600; lk_asid = 8'd1;
        @(negedge clk); #1;
        check("R4 fault path request", jt_req, 1'b1);
        lk_vpn = 20'h00100;
        #1;
        check("R5 resident page no hit", lk_hit, 1'b0);
        check("R5 resident page stall", lk_stall, 1'b1);
        check("R4 captured page held", jt_vpn, 20'h00600);
        lk_valid = 1'b0;
        jt_rsp_valid = 1'b1; jt_rsp_miss = 1'b1; jt_rsp_pfn = 24'hFFFFFF;
        #1;
        check("R8 fault raised", lk_fault, 1'b1);
        @(negedge clk);
        jt_rsp_valid = 1'b0; jt_rsp_miss = 1'b0;
        #1;
        check("R8 back to idle", jt_req, 1'b0);
        check("R8 fault pulse ends", lk_fault, 1'b0);
        lookup("R8 faulted page absent", 20'h00600, 8'd1, 1'b0, '0);
        lookup("R8 A unchanged", 20'h00100, 8'd1, 1'b1, 24'hA00001);
        lookup("R8 E unchanged", 20'h00500, 8'd1, 1'b1, 24'hE00005);
    endtask

    task automatic t_stray();
        @(negedge clk);
        lk_valid = 1'b0;
        jt_rsp_valid = 1'b1; jt_rsp_global = 1'b1; jt_rsp_pfn = 24'h777777;
        @(negedge clk);
        jt_rsp_valid = 1'b0;
        lookup("R10 idle answer ignored", 20'h00000, 8'd0, 1'b0, '0);
        lookup("R10 B still intact", 20'h00200, 8'd1, 1'b1, 24'hB00002);
    endtask

    task automatic t_flush();
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h00700; lk_asid = 8'd3;
        @(negedge clk); #1;
        check("R9 pending before flush", jt_req, 1'b1);
        flush = 1'b1; lk_valid = 1'b0;
        @(negedge clk);
        flush = 1'b0;
        #1;
        check("R9 flush cancels request", jt_req, 1'b0);
        jt_rsp_valid = 1'b1; jt_rsp_miss = 1'b0; jt_rsp_global = 1'b0;
        jt_rsp_pfn = 24'h123456;
        #1;
        check("R10 late answer no fault", lk_fault, 1'b0);
        @(negedge clk);
        jt_rsp_valid = 1'b0;
        lookup("R10 late answer not written", 20'h00700, 8'd3, 1'b0, '0);
        lookup("R9 A invalidated", 20'h00100, 8'd1, 1'b0, '0);
        lookup("R9 D invalidated", 20'h00400, 8'd1, 1'b0, '0);
        lookup("R9 E invalidated", 20'h00500, 8'd1, 1'b0, '0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill();
        t_asid();
        t_victim();
        t_fault();
        t_stray();
        t_flush();
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule